// File: doc/BRIEF.md
# Status Line Glitch Filter

This block cleans up the raw line-state and comparator signals of a charger-detection front end before they reach a readable status register. It takes two classes of raw bits. The slow class covers the D+ line state, the D- line state and the ID comparator. The fast class covers the charger-detect comparator. Each bit first passes through a synchronizer. It then goes to its own qualification counter. The filtered bit takes a new value only after the synchronized input has held that value for a full qualification window, so short glitches are removed. A change that holds still reaches the output within a bounded number of cycles.

Each class has three parameters, all in clock cycles: the longest glitch that must always be rejected, the qualification window, and the largest update delay allowed. Elaboration rejects any combination in which the window is shorter than the glitch limit, or in which the window plus the synchronizer depth cannot be met inside the delay limit. A pulse from the register interface marks every write to the associated control register. That pulse restarts the window of every bit and clears every bit's valid flag, so software knows when a status read reflects the new control setting. Debouncing longer than the windows is left to software that polls the status.

Top module: `status_glitch_filter`

## Requirements
- R1: While reset is asserted and right after it is released, every status bit and every valid flag is 0. With constant inputs, the valid flags of a class go to 1 on the QUAL-th rising edge after reset is released, where QUAL is that class's qualification window.
- R2: A slow-class input pulse that lasts at most SLOW_QUAL clock cycles never changes the slow status bit, and this always covers pulses of SLOW_GLITCH cycles or fewer. A pulse of SLOW_QUAL+1 cycles or longer does reach the output.
- R3: A held change on a slow input appears at the status output on the (SLOW_QUAL+SYNC_STAGES+1)-th rising edge after the first edge that samples it. This is never later than SLOW_MAXDLY cycles.
- R4: A fast-class input pulse that lasts at most FAST_QUAL cycles never changes the fast status bit, and this always covers pulses of FAST_GLITCH cycles or fewer. A pulse of FAST_QUAL+1 cycles or longer does reach the output.
- R5: A held change on a fast input appears on the (FAST_QUAL+SYNC_STAGES+1)-th rising edge after the first edge that samples it. This is never later than FAST_MAXDLY cycles.
- R6: A control-write pulse sampled on an edge clears every valid flag on that edge and leaves every status bit unchanged. A flag goes back to 1 exactly QUAL edges later (the write edge counts as edge 1, so the flag is 1 from edge QUAL+1 on), as long as the inputs stay still.
- R7: A control write that arrives while a bit is still qualifying a change restarts that bit's window. The change then appears QUAL edges after the write edge.
- R8: When one raw input changes, the valid flag of that bit drops on the (SYNC_STAGES+1)-th edge after the change is first sampled. The valid flags of all other bits stay at 1.
- R9: A status bit changes only on the edge where its valid flag rises. While the flag was already 1 on the previous cycle, the status bit holds.
- R10: Elaboration rejects a configuration in which a class's glitch limit exceeds its window, its window plus SYNC_STAGES+1 exceeds its delay limit, or any width or window is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock; all windows are counted in its cycles |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | One-cycle pulse for every write to the associated control register |
| slow_raw_i | input | SLOW_BITS | Raw slow-class inputs (bit 0 D+, bit 1 D-, bit 2 ID comparator) |
| fast_raw_i | input | FAST_BITS | Raw fast-class inputs (charger-detect comparator) |
| slow_stat_o | output | SLOW_BITS | Filtered slow-class status bits |
| slow_vld_o | output | SLOW_BITS | Per-bit flag: slow status is qualified since the last change or write |
| fast_stat_o | output | FAST_BITS | Filtered fast-class status bits |
| fast_vld_o | output | FAST_BITS | Per-bit flag: fast status is qualified since the last change or write |

## Verification
Four properties are checked on every cycle, for every bit:
- a status bit moves only as its valid flag rises;
- it stays put while the flag was already high;
- a control write clears the flag on the next cycle;
- once a raw input and the control write have both been quiet for the class delay limit, the status bit equals the raw input.

Some behaviour depends on how long a pulse lasted or on the exact edge of an update, and only the bench scenarios show it. The bench sweeps every pulse width from one cycle to past the window on every bit of both classes. It also times each update to the exact edge, times how valid flags recover after reset and after a write, and checks that bits stay independent.

// File: rtl/sgf_pkg.sv
package sgf_pkg;

   // Number of bits needed to hold a count from 0 up to lim.
   function automatic int cnt_bits(input int lim);
      return (lim < 2) ? 1 : $clog2(lim + 1);
   endfunction

   // Larger of two counts, used to size shared counters.
   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sgf_sync.sv
module sgf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         // Inputs are already in this clock domain.
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] ff_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               ff_q <= '0;
            end else begin
               ff_q[0] <= d_i;
               for (int k = 1; k < STAGES; k++) begin
                  ff_q[k] <= ff_q[k-1];
               end
            end
         end

         assign q_o = ff_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sgf_chan.sv
module sgf_chan #(
   parameter int QUAL = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic restart_i,
   input  logic s_i,
   output logic stat_o,
   output logic vld_o
);

   import sgf_pkg::*;

   localparam int CW = cnt_bits(QUAL);
   localparam logic [CW-1:0] LAST_CNT = CW'(QUAL - 1);

   logic          last_q;
   logic          stat_q;
   logic          vld_q;
   logic [CW-1:0] cnt_q;
   logic          moved;

   // The synchronized input differs from the value seen one cycle ago.
   assign moved = (s_i != last_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         last_q <= 1'b0;
         stat_q <= 1'b0;
         vld_q  <= 1'b0;
         cnt_q  <= '0;
      end else begin
         last_q <= s_i;
         if (restart_i || moved) begin
            // Begin a new window; the held status is kept as it is.
            cnt_q <= '0;
            vld_q <= 1'b0;
         end else if (!vld_q) begin
            if (cnt_q == LAST_CNT) begin
               stat_q <= s_i;
               vld_q  <= 1'b1;
            end
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   assign stat_o = stat_q;
   assign vld_o  = vld_q;

endmodule

// File: rtl/sgf_bank.sv
module sgf_bank #(
   parameter int WIDTH       = 3,
   parameter int QUAL        = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] stat_o,
   output logic [WIDTH-1:0] vld_o
);

   logic [WIDTH-1:0] synced;

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         sgf_sync #(
            .STAGES (SYNC_STAGES)
         ) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .d_i    (raw_i[b]),
            .q_o    (synced[b])
         );

         sgf_chan #(
            .QUAL (QUAL)
         ) u_chan (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .restart_i (restart_i),
            .s_i       (synced[b]),
            .stat_o    (stat_o[b]),
            .vld_o     (vld_o[b])
         );
      end
   endgenerate

endmodule

// File: rtl/status_glitch_filter.sv
module status_glitch_filter #(
   parameter int SLOW_BITS   = 3,
   parameter int FAST_BITS   = 1,
   parameter int SYNC_STAGES = 2,
   // Windows in clock cycles; defaults assume a 200 MHz clock.
   parameter int SLOW_GLITCH = 90000,
   parameter int SLOW_QUAL   = 100000,
   parameter int SLOW_MAXDLY = 112000,
   parameter int FAST_GLITCH = 6000,
   parameter int FAST_QUAL   = 16000,
   parameter int FAST_MAXDLY = 28000
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 ctrl_wr_i,
   input  logic [SLOW_BITS-1:0] slow_raw_i,
   input  logic [FAST_BITS-1:0] fast_raw_i,
   output logic [SLOW_BITS-1:0] slow_stat_o,
   output logic [SLOW_BITS-1:0] slow_vld_o,
   output logic [FAST_BITS-1:0] fast_stat_o,
   output logic [FAST_BITS-1:0] fast_vld_o
);

   // R10: configuration checks at elaboration
   generate
      if (SLOW_BITS < 1 || FAST_BITS < 1) begin : g_bad_width
         $error("status_glitch_filter: each class needs at least one bit");
      end
      if (SLOW_QUAL < 1 || FAST_QUAL < 1) begin : g_bad_qual
         $error("status_glitch_filter: qualification windows must be nonzero");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("status_glitch_filter: synchronizer depth cannot be negative");
      end
      if (SLOW_GLITCH > SLOW_QUAL) begin : g_slow_glitch
         $error("status_glitch_filter: slow window shorter than slow glitch limit");
      end
      if (FAST_GLITCH > FAST_QUAL) begin : g_fast_glitch
         $error("status_glitch_filter: fast window shorter than fast glitch limit");
      end
      if (SLOW_QUAL + SYNC_STAGES + 1 > SLOW_MAXDLY) begin : g_slow_dly
         $error("status_glitch_filter: slow update cannot meet its delay limit");
      end
      if (FAST_QUAL + SYNC_STAGES + 1 > FAST_MAXDLY) begin : g_fast_dly
         $error("status_glitch_filter: fast update cannot meet its delay limit");
      end
   endgenerate

   sgf_bank #(
      .WIDTH       (SLOW_BITS),
      .QUAL        (SLOW_QUAL),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_slow (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (ctrl_wr_i),
      .raw_i     (slow_raw_i),
      .stat_o    (slow_stat_o),
      .vld_o     (slow_vld_o)
   );

   sgf_bank #(
      .WIDTH       (FAST_BITS),
      .QUAL        (FAST_QUAL),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_fast (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (ctrl_wr_i),
      .raw_i     (fast_raw_i),
      .stat_o    (fast_stat_o),
      .vld_o     (fast_vld_o)
   );

endmodule

// File: rtl/sgf_checker.sv
module sgf_checker #(
   parameter int SLOW_BITS   = 3,
   parameter int FAST_BITS   = 1,
   parameter int SLOW_MAXDLY = 112000,
   parameter int FAST_MAXDLY = 28000
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 ctrl_wr_i,
   input logic [SLOW_BITS-1:0] slow_raw_i,
   input logic [FAST_BITS-1:0] fast_raw_i,
   input logic [SLOW_BITS-1:0] slow_stat_o,
   input logic [SLOW_BITS-1:0] slow_vld_o,
   input logic [FAST_BITS-1:0] fast_stat_o,
   input logic [FAST_BITS-1:0] fast_vld_o
);

   import sgf_pkg::*;

   localparam int NB = SLOW_BITS + FAST_BITS;
   localparam int AW = cnt_bits(max_of(SLOW_MAXDLY, FAST_MAXDLY));

   logic [NB-1:0] raw;
   logic [NB-1:0] stat;
   logic [NB-1:0] vld;

   assign raw  = {fast_raw_i, slow_raw_i};
   assign stat = {fast_stat_o, slow_stat_o};
   assign vld  = {fast_vld_o, slow_vld_o};

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bit
         localparam int LIM = (b < SLOW_BITS) ? SLOW_MAXDLY : FAST_MAXDLY;

         // Cycles since this raw input or the control write last moved.
         logic [AW-1:0] age_q;
         logic          prev_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               age_q  <= '0;
               prev_q <= 1'b0;
            end else begin
               prev_q <= raw[b];
               if (raw[b] != prev_q || ctrl_wr_i) begin
                  age_q <= '0;
               end else if (age_q != AW'(LIM)) begin
                  age_q <= age_q + AW'(1);
               end
            end
         end

         // R9
         stat_moves_on_vld_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !$stable(stat[b]) |-> $rose(vld[b]));

         // R9
         stat_held_while_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(vld[b]) |-> $stable(stat[b]));

         // R6
         wr_clears_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ctrl_wr_i |=> !vld[b]);

         // R3 and R5
         update_within_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (int'(age_q) >= LIM && raw[b] == prev_q && !ctrl_wr_i) |-> (stat[b] == raw[b]));
      end
   endgenerate

endmodule

bind status_glitch_filter sgf_checker #(
   .SLOW_BITS   (SLOW_BITS),
   .FAST_BITS   (FAST_BITS),
   .SLOW_MAXDLY (SLOW_MAXDLY),
   .FAST_MAXDLY (FAST_MAXDLY)
) u_sgf_checker (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .ctrl_wr_i   (ctrl_wr_i),
   .slow_raw_i  (slow_raw_i),
   .fast_raw_i  (fast_raw_i),
   .slow_stat_o (slow_stat_o),
   .slow_vld_o  (slow_vld_o),
   .fast_stat_o (fast_stat_o),
   .fast_vld_o  (fast_vld_o)
);

// File: tb/status_glitch_filter_tb.sv
`timescale 1ns/1ps
module status_glitch_filter_tb;

   localparam int SB  = 3;
   localparam int FB  = 1;
   localparam int SY  = 2;
   localparam int SG  = 10;
   localparam int SQ  = 12;
   localparam int SMD = 16;
   localparam int FG  = 3;
   localparam int FQ  = 4;
   localparam int FMD = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr = 1'b0;
   logic [SB-1:0] sraw = '0;
   logic [FB-1:0] fraw = '0;
   logic [SB-1:0] s_stat, s_vld;
   logic [FB-1:0] f_stat, f_vld;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   status_glitch_filter #(
      .SLOW_BITS   (SB),
      .FAST_BITS   (FB),
      .SYNC_STAGES (SY),
      .SLOW_GLITCH (SG),
      .SLOW_QUAL   (SQ),
      .SLOW_MAXDLY (SMD),
      .FAST_GLITCH (FG),
      .FAST_QUAL   (FQ),
      .FAST_MAXDLY (FMD)
   ) u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .ctrl_wr_i   (wr),
      .slow_raw_i  (sraw),
      .fast_raw_i  (fraw),
      .slow_stat_o (s_stat),
      .slow_vld_o  (s_vld),
      .fast_stat_o (f_stat),
      .fast_vld_o  (f_vld)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic settle();
      repeat (SMD + 4) step();
   endtask

   // Pulse one raw bit high for w sampled cycles; see whether and when it passes.
   task automatic run_pulse(input bit fast, input int idx, input int w);
      int    q;
      int    md;
      int    first;
      bit    seen;
      bit    cur;
      bit    pass;
      string rq;
      string rl;
      q     = fast ? FQ : SQ;
      md    = fast ? FMD : SMD;
      rq    = fast ? "R4" : "R2";
      rl    = fast ? "R5" : "R3";
      first = 0;
      seen  = 1'b0;
      cur   = 1'b0;
      pass  = (w >= q + 1);
      settle();
      if (fast) fraw[idx] = 1'b1; else sraw[idx] = 1'b1;
      for (int k = 1; k <= w + q + SY + 3; k++) begin
         step();
         cur = fast ? f_stat[idx] : s_stat[idx];
         if (cur && !seen) begin
            seen  = 1'b1;
            first = k;
         end
         if (k == w) begin
            if (fast) fraw[idx] = 1'b0; else sraw[idx] = 1'b0;
         end
      end
      check(seen == pass, rq, int'(seen), int'(pass));
      if (pass) begin
         check(first == q + SY + 1, rl, first, q + SY + 1);
         check(first <= md, rl, first, md);
      end
      check(cur == 1'b0, rq, int'(cur), 0);
   endtask

   initial begin
      // R1: state while in reset and just after release
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(s_stat == '0 && f_stat == '0, "R1", int'({f_stat, s_stat}), 0);
      check(s_vld == '0 && f_vld == '0, "R1", int'({f_vld, s_vld}), 0);
      rst_n = 1'b1;
      for (int k = 1; k <= SQ + 1; k++) begin
         step();
         check(f_vld == {FB{k >= FQ}}, "R1", int'(f_vld), int'(k >= FQ));
         check(s_vld == {SB{k >= SQ}}, "R1", int'(s_vld), (k >= SQ) ? 7 : 0);
         check(s_stat == '0 && f_stat == '0, "R1", int'({f_stat, s_stat}), 0);
      end

      // R6: a write clears the flags, keeps the status, and the flags recover
      sraw = 3'b101;
      fraw = 1'b1;
      settle();
      wr = 1'b1;
      for (int k = 1; k <= SQ + 1; k++) begin
         step();
         if (k == 1) wr = 1'b0;
         check(s_vld == {SB{k >= SQ + 1}}, "R6", int'(s_vld), (k >= SQ + 1) ? 7 : 0);
         check(f_vld == {FB{k >= FQ + 1}}, "R6", int'(f_vld), int'(k >= FQ + 1));
         check(s_stat == 3'b101 && f_stat == 1'b1, "R6", int'({f_stat, s_stat}), 13);
      end

      // R8: only the bit whose input moved loses its flag, at the expected edge
      settle();
      sraw[1] = 1'b1;
      for (int k = 1; k <= SY + 1; k++) begin
         step();
         check(s_vld == ((k < SY + 1) ? 3'b111 : 3'b101), "R8", int'(s_vld),
               (k < SY + 1) ? 7 : 5);
         check(f_vld == 1'b1, "R8", int'(f_vld), 1);
      end

      // R7: a write in mid-qualification restarts the window
      settle();
      check(s_stat == 3'b111, "R7", int'(s_stat), 7);
      sraw[2] = 1'b0;
      for (int k = 1; k <= SQ + 7; k++) begin
         step();
         check(s_stat[2] == ((k >= SQ + 6) ? 1'b0 : 1'b1), "R7", int'(s_stat[2]),
               (k >= SQ + 6) ? 0 : 1);
         if (k == 5) wr = 1'b1;
         if (k == 6) wr = 1'b0;
      end
      sraw = '0;
      fraw = '0;
      settle();

      // R2 and R3: pulse width sweep on every slow bit
      for (int b = 0; b < SB; b++) begin
         for (int w = 1; w <= SQ + 3; w++) begin
            run_pulse(1'b0, b, w);
         end
      end

      // R4 and R5: pulse width sweep on every fast bit
      for (int b = 0; b < FB; b++) begin
         for (int w = 1; w <= FQ + 3; w++) begin
            run_pulse(1'b1, b, w);
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule